// File: doc/BRIEF.md
# Page-Mapping Address Translator

This block widens a 16-bit logical CPU address to a 20-bit physical one. The top four logical bits pick one of sixteen mapping entries. The chosen entry gives the upper eight physical bits, and the low twelve logical bits pass straight through as the page offset. Each entry holds the one's complement of the physical page it stands for. The block inverts the whole byte on the way out, so software always writes the complement of the page number it wants.

Software cannot read the entries back; it can only write them. The address decoder asserts a select for the write window at the top of the logical space. Bits 3..0 of the logical address then name the entry, and the data bus carries the new value. The block runs on a fast system clock and treats the E and Q bus-phase clocks as level inputs. A write is accepted only when select is high and R/W is low at every sample while E is high. The write commits when E falls. A request or an R/W glitch seen while only Q is high therefore leaves the map untouched.

The block also flags when the translated address falls in the on-board RAM window. A jumper input moves the window's upper limit up by one page.

Top module: `dat_xlate`

## Requirements
- R1: `phys_addr[19:12]` equals the bitwise complement of the entry selected by `log_addr[15:12]`.
- R2: After reset, entry n holds the complement of n, so logical page n maps to physical page n (upper byte 0x0n).
- R3: While `e_clk` is high, if every sample has `dat_sel`=1 and `rw`=0, then entry `log_addr[3:0]` takes the value `data_in` sampled while E was high and Q low. The write commits on the first clock at which `e_clk` is seen low, and `log_addr[4]` plays no part in choosing the entry.
- R4: A write request (`dat_sel`=1, `rw`=0) presented only while `e_clk` is low (Q-only phase) changes no entry.
- R5: If `rw` is sampled high at any point while `e_clk` is high, that bus cycle writes nothing, even when `rw` is low for the rest of E-high.
- R6: A cycle with `dat_sel` low, or a read cycle (`rw`=1 throughout), changes no entry.
- R7: A translation of the page being written shows the old mapping for as long as `e_clk` is high, and shows the new mapping after E falls.
- R8: With `hi_ram_jmp`=0, `ram_hit` is 1 exactly when the physical page byte is in 0xC0..0xFD.
- R9: With `hi_ram_jmp`=1, `ram_hit` is 1 exactly when the physical page byte is in 0xC0..0xFE. Page 0xFF never hits.
- R10: `phys_addr[11:0]` equals `log_addr[11:0]` for every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, faster than E/Q |
| rst_n | input | 1 | Active-low synchronous reset |
| log_addr | input | 16 | Logical CPU address |
| data_in | input | 8 | CPU data bus (write value) |
| rw | input | 1 | 1 = read, 0 = write |
| dat_sel | input | 1 | Decoded select of the mapping write window |
| e_clk | input | 1 | Bus E phase clock (level) |
| q_clk | input | 1 | Bus Q phase clock (level) |
| hi_ram_jmp | input | 1 | Jumper: extend RAM window by one page |
| phys_addr | output | 20 | Translated physical address |
| ram_hit | output | 1 | Physical address lies in on-board RAM window |

## Verification
The hardest case to reach is a bus cycle that carries a valid-looking write request but must be rejected. This covers a request held only during the Q-leading phase, and a request whose R/W rises briefly in the middle of E-high. The bench drives whole bus cycles phase by phase. A mode argument shifts the R/W transitions to those windows. After each such cycle it translates the targeted page to show that the old mapping survived. The same task samples the translation of the page being written once in the middle of E-high and again after E falls. Those two samples give the old-then-new ordering.

// File: rtl/dat_pkg.sv
package dat_pkg;
  localparam int DAT_LA_W      = 16;
  localparam int DAT_PAGE_BITS = 4;
  localparam int DAT_XW        = 8;
  localparam int DAT_IDX_W     = 4;

  // Complement code that maps logical page n onto physical page n
  function automatic logic [DAT_XW-1:0] ident_code(input int unsigned n);
    logic [DAT_XW-1:0] v;
    v = DAT_XW'(n);
    return ~v;
  endfunction

  // Inclusive page-range test used for the RAM window
  function automatic logic page_in_range(input logic [DAT_XW-1:0] pg,
                                         input logic [DAT_XW-1:0] lo,
                                         input logic [DAT_XW-1:0] hi);
    return (pg >= lo) && (pg <= hi);
  endfunction
endpackage

// File: rtl/dat_wr_qual.sv
module dat_wr_qual #(
  parameter int IDX_W = 4,
  parameter int XW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             e_clk,
  input  logic             q_clk,
  input  logic             rw,
  input  logic             sel,
  input  logic [IDX_W-1:0] addr_lo,
  input  logic [XW-1:0]    din,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [XW-1:0]    wr_data
);
  logic             e_d;
  logic             pend;
  logic [IDX_W-1:0] idx_q;
  logic [XW-1:0]    dat_q;

  wire e_rise = e_clk & ~e_d;
  wire e_fall = ~e_clk & e_d;
  wire req    = sel & ~rw;
  wire late_e = e_clk & ~q_clk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_d   <= 1'b0;
      pend  <= 1'b0;
      idx_q <= '0;
      dat_q <= '0;
    end else begin
      e_d <= e_clk;
      if (e_clk) begin
        pend <= e_rise ? req : (pend & req);
        if (late_e) begin
          idx_q <= addr_lo;
          dat_q <= din;
        end
      end else begin
        pend <= 1'b0;
      end
    end
  end

  assign wr_en   = e_fall & pend;
  assign wr_idx  = idx_q;
  assign wr_data = dat_q;

  // R4
  q_only_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!e_clk && !$past(e_clk)) |-> !wr_en);

  // R5
  rw_glitch_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (e_clk && rw) |=> !pend);
endmodule

// File: rtl/dat_regfile.sv
module dat_regfile
  import dat_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int XW      = 8,
  parameter int ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [XW-1:0]    rd_page
);
  logic [XW-1:0]         mem [ENTRIES];
  logic [ENTRIES*XW-1:0] mem_flat;

  for (genvar n = 0; n < ENTRIES; n++) begin : g_ent
    wire hit = wr_en && (wr_idx == IDX_W'(n));
    always_ff @(posedge clk) begin
      if (!rst_n)   mem[n] <= XW'(ident_code(n));
      else if (hit) mem[n] <= wr_data;
    end
    assign mem_flat[n*XW +: XW] = mem[n];
  end

  // stored byte is complemented on the way out
  assign rd_page = ~mem[rd_idx];

  // R3
  entry_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_idx)] == $past(wr_data)));

  // R6
  idle_map_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem_flat));
endmodule

// File: rtl/dat_ram_window.sv
module dat_ram_window
  import dat_pkg::*;
#(
  parameter int             XW         = 8,
  parameter logic [XW-1:0]  LO_PAGE    = 8'hC0,
  parameter logic [XW-1:0]  HI_PAGE    = 8'hFD,
  parameter logic [XW-1:0]  HI_PAGE_JP = 8'hFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] page,
  input  logic          hi_jmp,
  output logic          hit
);
  logic [XW-1:0] top_page;
  assign top_page = hi_jmp ? HI_PAGE_JP : HI_PAGE;
  assign hit      = page_in_range(page, LO_PAGE, top_page);

  // R8
  below_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (page >= LO_PAGE));

  // R9
  jumper_gates_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_jmp && page > HI_PAGE) |-> !hit);
endmodule

// File: rtl/dat_xlate.sv
module dat_xlate
  import dat_pkg::*;
#(
  parameter int LA_W      = DAT_LA_W,
  parameter int PAGE_BITS = DAT_PAGE_BITS,
  parameter int XW        = DAT_XW,
  parameter int IDX_W     = DAT_IDX_W,
  localparam int OFFS_W   = LA_W - PAGE_BITS,
  localparam int PA_W     = XW + OFFS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LA_W-1:0] log_addr,
  input  logic [XW-1:0]   data_in,
  input  logic            rw,
  input  logic            dat_sel,
  input  logic            e_clk,
  input  logic            q_clk,
  input  logic            hi_ram_jmp,
  output logic [PA_W-1:0] phys_addr,
  output logic            ram_hit
);
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [XW-1:0]    wr_data;
  logic [XW-1:0]    xpage;

  dat_wr_qual #(.IDX_W(IDX_W), .XW(XW)) u_qual (
    .clk(clk), .rst_n(rst_n), .e_clk(e_clk), .q_clk(q_clk), .rw(rw),
    .sel(dat_sel), .addr_lo(log_addr[IDX_W-1:0]), .din(data_in),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  dat_regfile #(.IDX_W(PAGE_BITS), .XW(XW)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_idx(PAGE_BITS'(wr_idx)), .wr_data(wr_data),
    .rd_idx(log_addr[LA_W-1 -: PAGE_BITS]), .rd_page(xpage)
  );

  dat_ram_window #(.XW(XW)) u_win (
    .clk(clk), .rst_n(rst_n), .page(xpage), .hi_jmp(hi_ram_jmp), .hit(ram_hit)
  );

  assign phys_addr = {xpage, log_addr[OFFS_W-1:0]};
endmodule

// File: tb/test_dat_xlate.sv
module test_dat_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] log_addr = 16'h0000;
  logic [7:0]  data_in = 8'h00;
  logic        rw = 1'b1, dat_sel = 1'b0, e_clk = 1'b0, q_clk = 1'b0;
  logic        hi_ram_jmp = 1'b0;
  logic [19:0] phys_addr;
  logic        ram_hit;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  dat_xlate i_dat_xlate (
    .clk(clk), .rst_n(rst_n), .log_addr(log_addr), .data_in(data_in), .rw(rw),
    .dat_sel(dat_sel), .e_clk(e_clk), .q_clk(q_clk), .hi_ram_jmp(hi_ram_jmp),
    .phys_addr(phys_addr), .ram_hit(ram_hit)
  );

  // {entry, value written}; expected physical page is the complement
  localparam logic [11:0] VEC [8] = '{
    12'h0_FF, 12'h1_3F, 12'h7_A5, 12'h9_00,
    12'hA_5A, 12'hC_81, 12'hE_F0, 12'h3_C3
  };

  function automatic logic [7:0] want_page(input logic [7:0] stored);
    return stored ^ 8'hFF;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // mode 0 normal, 1 rw spike in E-high, 2 request only in Q-only phase
  task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d,
                           input logic r, input logic s, input int mode,
                           output logic [7:0] mid_pg, output logic [7:0] end_pg);
    @(negedge clk);
    log_addr = a; data_in = d; dat_sel = s; q_clk = 1; e_clk = 0;
    rw = (mode == 2) ? 1'b0 : r;
    ticks(2);
    e_clk = 1;
    if (mode == 2) rw = 1'b1;
    ticks(2);
    q_clk = 0;
    if (mode == 1) begin rw = 1'b1; ticks(1); rw = r; ticks(1); end
    else ticks(2);
    mid_pg = phys_addr[19:12];
    e_clk = 0;
    ticks(2);
    end_pg = phys_addr[19:12];
    rw = 1; dat_sel = 0;
  endtask

  task automatic look(input logic [15:0] a);
    log_addr = a;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    logic [7:0] m, e;
    bus_cycle({12'hFFE, idx}, d, 1'b0, 1'b1, 0, m, e);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] m, e;
    ticks(3);
    rst_n = 1;
    ticks(1);
    // R2 identity map after reset, R10 offset passthrough
    for (int p = 0; p < 16; p++) begin
      look({p[3:0], 12'hA5C});
      chk(phys_addr[19:12], {4'h0, p[3:0]}, "R2");
      chk(phys_addr[11:0], 12'hA5C, "R10");
    end
    // R1/R3 vector walk
    for (int v = 0; v < 8; v++) begin
      wr(VEC[v][11:8], VEC[v][7:0]);
      look({VEC[v][11:8], 12'h123});
      chk(phys_addr[19:12], want_page(VEC[v][7:0]), "R1/R3");
      chk(phys_addr[11:0], 12'h123, "R10");
    end
    // R3 bit 4 of address ignored: FFF5 hits entry 5
    bus_cycle(16'hFFF5, 8'h2D, 1'b0, 1'b1, 0, m, e);
    look(16'h5000);
    chk(phys_addr[19:12], 8'hD2, "R3 idx");
    // R4 Q-only request
    bus_cycle(16'hFFE5, 8'h77, 1'b0, 1'b1, 2, m, e);
    look(16'h5000);
    chk(phys_addr[19:12], 8'hD2, "R4");
    // R5 rw spike during E-high
    bus_cycle(16'hFFE5, 8'h66, 1'b0, 1'b1, 1, m, e);
    look(16'h5000);
    chk(phys_addr[19:12], 8'hD2, "R5");
    // R6 read cycle and deselected write
    bus_cycle(16'hFFE5, 8'h55, 1'b1, 1'b1, 0, m, e);
    bus_cycle(16'hFFE5, 8'h44, 1'b0, 1'b0, 0, m, e);
    look(16'h5000);
    chk(phys_addr[19:12], 8'hD2, "R6");
    // R7 write to entry F while translating page F
    bus_cycle(16'hFFEF, 8'h0F, 1'b0, 1'b1, 0, m, e);
    chk(m, 8'h0F, "R7 old");
    chk(e, 8'hF0, "R7 new");
    // R8/R9 RAM window
    wr(4'h1, 8'h3F); wr(4'h2, 8'h02); wr(4'h3, 8'h01);
    wr(4'h4, 8'h00); wr(4'h6, 8'h40);
    hi_ram_jmp = 0;
    look(16'h1000); chk(ram_hit, 1, "R8 C0");
    look(16'h2000); chk(ram_hit, 1, "R8 FD");
    look(16'h3000); chk(ram_hit, 0, "R8 FE");
    look(16'h4000); chk(ram_hit, 0, "R8 FF");
    look(16'h6000); chk(ram_hit, 0, "R8 BF");
    hi_ram_jmp = 1;
    look(16'h3000); chk(ram_hit, 1, "R9 FE");
    look(16'h4000); chk(ram_hit, 0, "R9 FF");
    look(16'h2000); chk(ram_hit, 1, "R9 FD");
    // R2 reset restores identity
    rst_n = 0; ticks(2); rst_n = 1; ticks(1);
    look(16'h7000);
    chk(phys_addr[19:12], 8'h07, "R2 rereset");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule